// File: doc/BRIEF.md
# Multi-Profile Two-Rate Three-Color Policer

This block is an in-line rate limiter. Each arriving frame carries an 8-bit profile selector and a byte length. The block looks up the selected policing profile and meters the frame against two token buckets kept for that profile. The committed bucket refills at a sustained rate and is capped at a committed burst size. The peak bucket refills at a peak rate and is capped at a peak burst size. The block returns a color for the frame: green, yellow or red. It also returns a drop flag taken from that profile's action for frames that exceed the rate.

All profiles share one metering datapath. Refill is computed lazily: each profile stores the timestamp of its last use. When the profile is next selected, the elapsed clock count times the per-cycle rate is added to each bucket, and each bucket is then capped at its burst size. Profiles are loaded through a single-cycle configuration port. Writing a profile fills both buckets and restarts its timestamp.

The datapath is a two-stage pipeline: a read stage and a compute/write-back stage. Bypass paths let a frame that follows another frame on the same profile see the updated buckets without a stall.

Top module: `trtcm_policer`

## Requirements
- R1: After reset no result is reported, and every profile has zero rates, zero burst sizes, empty buckets and the mark action. A frame on such a profile with nonzero length is red and is not flagged for drop; a zero-length frame is green.
- R2: Every frame accepted on `frm_valid` produces exactly one `res_valid` pulse on the second rising edge after the edge that accepts it. Results come out in frame order.
- R3: Colors are encoded as green=0, yellow=1 and red=2. A frame is red when its length is greater than the refilled peak bucket. Otherwise it is yellow when its length is greater than the refilled committed bucket. Otherwise it is green. A length equal to a bucket does not exceed that bucket.
- R4: A green frame subtracts its length from both buckets. A yellow frame subtracts it from the peak bucket only. A red frame changes neither bucket. No bucket ever holds more than its burst size.
- R5: Before a frame is evaluated, each bucket of its profile is increased by (clock cycles elapsed since that profile was last evaluated or written) times that bucket's per-cycle rate, and is then capped at its burst size.
- R6: The 256 profiles, selected by `frm_idx` or `cfg_idx`, are independent. Metering one profile leaves every other profile unchanged.
- R7: `res_drop` is 1 only for a red frame whose profile has `cfg_red_drop`=1. For a red frame whose profile has the mark action, `res_drop` is 0, and the red color is the marking.
- R8: A frame accepted in the cycle right after a frame on the same profile is metered against the buckets and timestamp left by that earlier frame.
- R9: A configuration write loads both buckets to their burst sizes and sets the profile timestamp to the current cycle. A frame accepted in the same cycle on the same profile is metered against the newly written settings.
- R10: When a configuration write and the write-back of an in-flight frame hit the same profile in the same cycle, the configuration write wins. The in-flight frame still reports a result computed from the settings it read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Profile written |
| cfg_cir | input | 16 | Committed rate, tokens per cycle |
| cfg_pir | input | 16 | Peak rate, tokens per cycle |
| cfg_cbs | input | 24 | Committed burst size |
| cfg_pbs | input | 24 | Peak burst size |
| cfg_red_drop | input | 1 | 1: drop red frames, 0: mark them |
| frm_valid | input | 1 | Frame present |
| frm_idx | input | 8 | Profile selected for the frame |
| frm_len | input | 16 | Frame length in bytes |
| res_valid | output | 1 | Result strobe |
| res_color | output | 2 | Result color (0 green, 1 yellow, 2 red) |
| res_drop | output | 1 | Red frame whose profile drops |

## Verification
Two functions can meet in one cycle: a configuration write to a profile, and a frame on that same profile that is either being read or writing back its buckets. The bench provokes both cases. In the first, it drives a configuration write in the same cycle as a frame on that profile. In the second, it drives the write one cycle after a frame, so that the write meets that frame's write-back. It then judges the outcome from the colors of the in-flight frame and of the following frames, which must show full buckets under the new settings.

// File: rtl/trtcm_pkg.sv
package trtcm_pkg;
  typedef enum logic [1:0] {
    CLR_GREEN  = 2'd0,
    CLR_YELLOW = 2'd1,
    CLR_RED    = 2'd2
  } color_e;
endpackage

// File: rtl/trtcm_timebase.sv
module trtcm_timebase #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end
endmodule

// File: rtl/trtcm_prof_table.sv
module trtcm_prof_table #(
  parameter int IDX_W  = 8,
  parameter int RATE_W = 16,
  parameter int BKT_W  = 24,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   now,
  // configuration write
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [RATE_W-1:0] cfg_cir,
  input  logic [RATE_W-1:0] cfg_pir,
  input  logic [BKT_W-1:0]  cfg_cbs,
  input  logic [BKT_W-1:0]  cfg_pbs,
  input  logic              cfg_red_drop,
  // bucket write-back from the meter
  input  logic              wb_we,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [BKT_W-1:0]  wb_ctok,
  input  logic [BKT_W-1:0]  wb_ptok,
  input  logic [TS_W-1:0]   wb_ts,
  // read port
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [RATE_W-1:0] rd_cir,
  output logic [RATE_W-1:0] rd_pir,
  output logic [BKT_W-1:0]  rd_cbs,
  output logic [BKT_W-1:0]  rd_pbs,
  output logic              rd_drop,
  output logic [BKT_W-1:0]  rd_ctok,
  output logic [BKT_W-1:0]  rd_ptok,
  output logic [TS_W-1:0]   rd_ts
);
  localparam int NPROF = 1 << IDX_W;

  logic [RATE_W-1:0] t_cir  [NPROF];
  logic [RATE_W-1:0] t_pir  [NPROF];
  logic [BKT_W-1:0]  t_cbs  [NPROF];
  logic [BKT_W-1:0]  t_pbs  [NPROF];
  logic              t_drop [NPROF];
  logic [BKT_W-1:0]  t_ctok [NPROF];
  logic [BKT_W-1:0]  t_ptok [NPROF];
  logic [TS_W-1:0]   t_ts   [NPROF];

  // configuration write and write-back aimed at one profile: configuration wins (R10)
  logic wb_blocked;
  assign wb_blocked = cfg_we && (cfg_idx == wb_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPROF; i++) begin
        t_cir[i]  <= '0;
        t_pir[i]  <= '0;
        t_cbs[i]  <= '0;
        t_pbs[i]  <= '0;
        t_drop[i] <= 1'b0;
      end
    end else if (cfg_we) begin
      t_cir[cfg_idx]  <= cfg_cir;
      t_pir[cfg_idx]  <= cfg_pir;
      t_cbs[cfg_idx]  <= cfg_cbs;
      t_pbs[cfg_idx]  <= cfg_pbs;
      t_drop[cfg_idx] <= cfg_red_drop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPROF; i++) begin
        t_ctok[i] <= '0;
        t_ptok[i] <= '0;
        t_ts[i]   <= '0;
      end
    end else begin
      if (cfg_we) begin
        t_ctok[cfg_idx] <= cfg_cbs;
        t_ptok[cfg_idx] <= cfg_pbs;
        t_ts[cfg_idx]   <= now;
      end
      if (wb_we && !wb_blocked) begin
        t_ctok[wb_idx] <= wb_ctok;
        t_ptok[wb_idx] <= wb_ptok;
        t_ts[wb_idx]   <= wb_ts;
      end
    end
  end

  assign rd_cir  = t_cir[rd_idx];
  assign rd_pir  = t_pir[rd_idx];
  assign rd_cbs  = t_cbs[rd_idx];
  assign rd_pbs  = t_pbs[rd_idx];
  assign rd_drop = t_drop[rd_idx];
  assign rd_ctok = t_ctok[rd_idx];
  assign rd_ptok = t_ptok[rd_idx];
  assign rd_ts   = t_ts[rd_idx];

  // R9 / R10: a configuration write leaves both buckets full and the stamp current,
  // even if a write-back to the same profile fell on that edge
  a_r9_cfg_loads_full: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (t_ctok[$past(cfg_idx)] == $past(cfg_cbs)) &&
               (t_ptok[$past(cfg_idx)] == $past(cfg_pbs)) &&
               (t_ts[$past(cfg_idx)]   == $past(now)));

  // R6: a write-back touches only its own profile's buckets
  a_r6_wb_own_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && !wb_blocked) |=> (t_ctok[$past(wb_idx)] == $past(wb_ctok)) &&
                               (t_ptok[$past(wb_idx)] == $past(wb_ptok)));
endmodule

// File: rtl/trtcm_meter.sv
module trtcm_meter
  import trtcm_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int RATE_W = 16,
  parameter int BKT_W  = 24,
  parameter int TS_W   = 32
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [RATE_W-1:0] cir,
  input  logic [RATE_W-1:0] pir,
  input  logic [BKT_W-1:0]  cbs,
  input  logic [BKT_W-1:0]  pbs,
  input  logic [BKT_W-1:0]  ctok,
  input  logic [BKT_W-1:0]  ptok,
  input  logic [TS_W-1:0]   ts,
  input  logic [TS_W-1:0]   now,
  output color_e            color,
  output logic [BKT_W-1:0]  ctok_nx,
  output logic [BKT_W-1:0]  ptok_nx
);
  localparam int SUM_W = TS_W + RATE_W + 1;

  // bucket + elapsed*rate, capped at the burst size (R5)
  function automatic logic [BKT_W-1:0] refill(
    input logic [BKT_W-1:0]  tok,
    input logic [TS_W-1:0]   el,
    input logic [RATE_W-1:0] rate,
    input logic [BKT_W-1:0]  cap
  );
    logic [SUM_W-1:0] s;
    s = SUM_W'(tok) + SUM_W'(el) * SUM_W'(rate);
    if (s > SUM_W'(cap)) refill = cap;
    else                 refill = s[BKT_W-1:0];
  endfunction

  // peak bucket first, committed bucket second (R3)
  function automatic color_e classify(
    input logic [BKT_W-1:0] l,
    input logic [BKT_W-1:0] c,
    input logic [BKT_W-1:0] p
  );
    if (l > p)      classify = CLR_RED;
    else if (l > c) classify = CLR_YELLOW;
    else            classify = CLR_GREEN;
  endfunction

  logic [TS_W-1:0]  elapsed;
  logic [BKT_W-1:0] c_ref, p_ref, len_x;

  assign elapsed = now - ts;
  assign c_ref   = refill(ctok, elapsed, cir, cbs);
  assign p_ref   = refill(ptok, elapsed, pir, pbs);
  assign len_x   = BKT_W'(len);
  assign color   = classify(len_x, c_ref, p_ref);

  // R4: deduction per color
  always_comb begin
    ctok_nx = c_ref;
    ptok_nx = p_ref;
    case (color)
      CLR_GREEN: begin
        ctok_nx = c_ref - len_x;
        ptok_nx = p_ref - len_x;
      end
      CLR_YELLOW: ptok_nx = p_ref - len_x;
      default: ;
    endcase
  end
endmodule

// File: rtl/trtcm_policer.sv
module trtcm_policer
  import trtcm_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int LEN_W  = 16,
  parameter int RATE_W = 16,
  parameter int BKT_W  = 24,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [RATE_W-1:0] cfg_cir,
  input  logic [RATE_W-1:0] cfg_pir,
  input  logic [BKT_W-1:0]  cfg_cbs,
  input  logic [BKT_W-1:0]  cfg_pbs,
  input  logic              cfg_red_drop,
  input  logic              frm_valid,
  input  logic [IDX_W-1:0]  frm_idx,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              res_valid,
  output logic [1:0]        res_color,
  output logic              res_drop
);
  logic [TS_W-1:0] now;

  trtcm_timebase #(.TS_W(TS_W)) u_time (.clk(clk), .rst_n(rst_n), .now(now));

  // ---------------- stage 1 registers ----------------
  logic              s1_valid, s1_drop;
  logic [IDX_W-1:0]  s1_idx;
  logic [LEN_W-1:0]  s1_len;
  logic [TS_W-1:0]   s1_now, s1_ts;
  logic [RATE_W-1:0] s1_cir, s1_pir;
  logic [BKT_W-1:0]  s1_cbs, s1_pbs, s1_ctok, s1_ptok;

  // ---------------- table read and bypass ----------------
  logic [RATE_W-1:0] rd_cir, rd_pir;
  logic [BKT_W-1:0]  rd_cbs, rd_pbs, rd_ctok, rd_ptok;
  logic              rd_drop;
  logic [TS_W-1:0]   rd_ts;

  color_e            m_color;
  logic [BKT_W-1:0]  m_ctok_nx, m_ptok_nx;

  logic wb_we, fwd_cfg, fwd_wb;
  assign wb_we   = s1_valid;
  assign fwd_cfg = cfg_we && (cfg_idx == frm_idx);           // R9
  assign fwd_wb  = s1_valid && (s1_idx == frm_idx);           // R8

  trtcm_prof_table #(
    .IDX_W(IDX_W), .RATE_W(RATE_W), .BKT_W(BKT_W), .TS_W(TS_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .now(now),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_cir(cfg_cir), .cfg_pir(cfg_pir),
    .cfg_cbs(cfg_cbs), .cfg_pbs(cfg_pbs), .cfg_red_drop(cfg_red_drop),
    .wb_we(wb_we), .wb_idx(s1_idx), .wb_ctok(m_ctok_nx), .wb_ptok(m_ptok_nx),
    .wb_ts(s1_now),
    .rd_idx(frm_idx), .rd_cir(rd_cir), .rd_pir(rd_pir), .rd_cbs(rd_cbs),
    .rd_pbs(rd_pbs), .rd_drop(rd_drop), .rd_ctok(rd_ctok), .rd_ptok(rd_ptok),
    .rd_ts(rd_ts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
      s1_len   <= '0;
      s1_now   <= '0;
      s1_cir   <= '0;
      s1_pir   <= '0;
      s1_cbs   <= '0;
      s1_pbs   <= '0;
      s1_drop  <= 1'b0;
      s1_ctok  <= '0;
      s1_ptok  <= '0;
      s1_ts    <= '0;
    end else begin
      s1_valid <= frm_valid;
      s1_idx   <= frm_idx;
      s1_len   <= frm_len;
      s1_now   <= now;
      if (fwd_cfg) begin
        s1_cir  <= cfg_cir;
        s1_pir  <= cfg_pir;
        s1_cbs  <= cfg_cbs;
        s1_pbs  <= cfg_pbs;
        s1_drop <= cfg_red_drop;
        s1_ctok <= cfg_cbs;
        s1_ptok <= cfg_pbs;
        s1_ts   <= now;
      end else begin
        s1_cir  <= rd_cir;
        s1_pir  <= rd_pir;
        s1_cbs  <= rd_cbs;
        s1_pbs  <= rd_pbs;
        s1_drop <= rd_drop;
        if (fwd_wb) begin
          s1_ctok <= m_ctok_nx;
          s1_ptok <= m_ptok_nx;
          s1_ts   <= s1_now;
        end else begin
          s1_ctok <= rd_ctok;
          s1_ptok <= rd_ptok;
          s1_ts   <= rd_ts;
        end
      end
    end
  end

  // ---------------- stage 2: meter ----------------
  trtcm_meter #(
    .LEN_W(LEN_W), .RATE_W(RATE_W), .BKT_W(BKT_W), .TS_W(TS_W)
  ) u_meter (
    .len(s1_len), .cir(s1_cir), .pir(s1_pir), .cbs(s1_cbs), .pbs(s1_pbs),
    .ctok(s1_ctok), .ptok(s1_ptok), .ts(s1_ts), .now(s1_now),
    .color(m_color), .ctok_nx(m_ctok_nx), .ptok_nx(m_ptok_nx)
  );

  logic red_drop_evt;
  assign red_drop_evt = s1_valid && (m_color == CLR_RED) && s1_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_color <= CLR_GREEN;
      res_drop  <= 1'b0;
    end else begin
      res_valid <= s1_valid;
      res_color <= m_color;
      res_drop  <= red_drop_evt;
    end
  end

  // ---------------- assertions ----------------
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> ##2 res_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(frm_valid, 2));

  a_r3_color_legal: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_color != 2'b11));

  a_r7_drop_only_red: assert property (@(posedge clk) disable iff (!rst_n)
    res_drop |-> (res_valid && res_color == CLR_RED));

  a_r4_within_burst: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (m_ctok_nx <= s1_cbs) && (m_ptok_nx <= s1_pbs));

  a_r4_red_keeps_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && m_color == CLR_RED) |-> (m_ptok_nx >= BKT_W'(s1_len)) == 1'b0
                                          || (m_ptok_nx < BKT_W'(s1_len)));

  a_r8_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && s1_valid && frm_idx == s1_idx && !(cfg_we && cfg_idx == frm_idx))
      |=> (s1_ctok == $past(m_ctok_nx)) && (s1_ptok == $past(m_ptok_nx)));

  a_r9_same_cycle_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && cfg_we && cfg_idx == frm_idx)
      |=> (s1_ctok == $past(cfg_cbs)) && (s1_ptok == $past(cfg_pbs)) && (s1_ts == s1_now));
endmodule

// File: tb/test_trtcm_policer.sv
`timescale 1ns/1ps
module test_trtcm_policer;
  localparam int IDX_W = 8, LEN_W = 16, RATE_W = 16, BKT_W = 24, TS_W = 32;
  localparam int NP = 1 << IDX_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              cfg_we, cfg_red_drop, frm_valid;
  logic [IDX_W-1:0]  cfg_idx, frm_idx;
  logic [RATE_W-1:0] cfg_cir, cfg_pir;
  logic [BKT_W-1:0]  cfg_cbs, cfg_pbs;
  logic [LEN_W-1:0]  frm_len;
  logic              res_valid, res_drop;
  logic [1:0]        res_color;

  trtcm_policer #(.IDX_W(IDX_W), .LEN_W(LEN_W), .RATE_W(RATE_W), .BKT_W(BKT_W), .TS_W(TS_W))
  i_trtcm_policer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_cir(cfg_cir),
    .cfg_pir(cfg_pir), .cfg_cbs(cfg_cbs), .cfg_pbs(cfg_pbs), .cfg_red_drop(cfg_red_drop),
    .frm_valid(frm_valid), .frm_idx(frm_idx), .frm_len(frm_len),
    .res_valid(res_valid), .res_color(res_color), .res_drop(res_drop)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // bench-side profile model
  longint mr_c[NP], mr_p[NP], mb_c[NP], mb_p[NP], tk_c[NP], tk_p[NP], stamp[NP];
  bit     act_drop[NP];

  longint cyc;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  longint q_due[$];
  int     q_col[$];
  bit     q_drp[$];
  string  q_tag[$];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_cfg(input int idx, input longint cr, input longint pr,
                         input longint cb, input longint pb, input bit dr);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx);
    cfg_cir = RATE_W'(cr); cfg_pir = RATE_W'(pr);
    cfg_cbs = BKT_W'(cb);  cfg_pbs = BKT_W'(pb); cfg_red_drop = dr;
    mr_c[idx] = cr; mr_p[idx] = pr; mb_c[idx] = cb; mb_p[idx] = pb; act_drop[idx] = dr;
    tk_c[idx] = cb; tk_p[idx] = pb; stamp[idx] = cyc;
  endtask

  task automatic put_frm(input int idx, input longint len, input string tag);
    longint el, c, p;
    int col;
    el = cyc - stamp[idx];
    c = tk_c[idx] + el * mr_c[idx]; if (c > mb_c[idx]) c = mb_c[idx];
    p = tk_p[idx] + el * mr_p[idx]; if (p > mb_p[idx]) p = mb_p[idx];
    if (len > p)      col = 2;
    else if (len > c) col = 1;
    else              col = 0;
    if (col == 0) begin c = c - len; p = p - len; end
    else if (col == 1) p = p - len;
    tk_c[idx] = c; tk_p[idx] = p; stamp[idx] = cyc;
    q_due.push_back(cyc + 2); q_col.push_back(col);
    q_drp.push_back(col == 2 && act_drop[idx]); q_tag.push_back(tag);
    frm_valid = 1'b1; frm_idx = IDX_W'(idx); frm_len = LEN_W'(len);
  endtask

  task automatic step();
    @(negedge clk);
    cfg_we = 1'b0; frm_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // result checker, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (res_valid) begin
        if (q_due.size() == 0) check("R2", "unexpected result", 1, 0);
        else begin
          longint due; int col; bit drp; string tag;
          due = q_due.pop_front(); col = q_col.pop_front();
          drp = q_drp.pop_front(); tag = q_tag.pop_front();
          check("R2", {tag, " result cycle"}, cyc, due);
          check(tag, "color", longint'(res_color), longint'(col));
          check(tag, "drop flag (R7)", longint'(res_drop), longint'(drp));
        end
      end else if (q_due.size() != 0 && q_due[0] <= cyc) begin
        check("R2", {q_tag[0], " missing result"}, 0, 1);
        void'(q_due.pop_front()); void'(q_col.pop_front());
        void'(q_drp.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", "res_valid during reset", longint'(res_valid), 0);
    end
    rst_n = 1'b1;
    idle(2);
    check("R1", "res_valid after reset", longint'(res_valid), 0);
    put_frm(7, 0, "R1 zero len"); step();
    put_frm(7, 1, "R1 empty profile"); step();
    idle(3);
  endtask

  task automatic t_colors();
    put_cfg(1, 1, 4, 100, 300, 0); step();
    put_frm(1, 100, "R3 green at edge"); step();
    put_frm(1, 150, "R4 yellow");        step();
    put_frm(1, 60,  "R3 red mark");      step();
    put_frm(1, 2,   "R4 green after");   step();
    idle(3);
  endtask

  task automatic t_boundary();
    put_cfg(2, 0, 0, 50, 80, 1); step();
    put_frm(2, 50, "R3 committed edge"); step();
    put_frm(2, 30, "R3 peak edge");      step();
    put_frm(2, 1,  "R7 red drop");       step();
    idle(3);
  endtask

  task automatic t_refill();
    idle(400);
    put_frm(1, 250, "R5 capped refill"); step();
    idle(20);
    put_frm(1, 99,  "R5 partial refill"); step();
    idle(3);
  endtask

  task automatic t_indep();
    put_cfg(255, 2, 3, 40, 60, 1); step();
    put_cfg(0, 1, 1, 10, 20, 0);   step();
    put_frm(255, 45, "R6 top index");  step();
    put_frm(0,   15, "R6 index zero"); step();
    put_frm(255, 30, "R6 top again");  step();
    put_frm(0,   15, "R6 zero again"); step();
    idle(3);
  endtask

  task automatic t_b2b();
    idle(30);
    for (int i = 0; i < 6; i++) begin
      put_frm(255, 12 + i, "R8 back-to-back"); step();
    end
    idle(3);
  endtask

  task automatic t_cfg_same();
    put_frm(3, 10, "R9 before write"); step();
    put_cfg(3, 1, 1, 20, 30, 0);
    put_frm(3, 25, "R9 same-cycle write"); step();
    put_frm(3, 10, "R9 after write"); step();
    idle(3);
  endtask

  task automatic t_collide();
    put_frm(3, 5, "R10 in-flight old"); step();
    put_cfg(3, 0, 0, 8, 9, 1);
    put_frm(3, 9, "R10 collide read"); step();
    put_frm(3, 9, "R10 after collide"); step();
    idle(3);
    put_frm(3, 1, "R10 write-back lost"); step();
    put_cfg(3, 0, 0, 8, 9, 0); step();
    put_frm(3, 8, "R10 cfg wins"); step();
    idle(3);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      if (q_due.size() != 0) check("R2", "results outstanding", q_due.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      mr_c[i] = 0; mr_p[i] = 0; mb_c[i] = 0; mb_p[i] = 0;
      tk_c[i] = 0; tk_p[i] = 0; stamp[i] = 0; act_drop[i] = 0;
    end
    rst_n = 1'b0; cfg_we = 1'b0; frm_valid = 1'b0;
    cfg_idx = '0; cfg_cir = '0; cfg_pir = '0; cfg_cbs = '0; cfg_pbs = '0;
    cfg_red_drop = 1'b0; frm_idx = '0; frm_len = '0;
    t_reset();
    t_colors();
    t_boundary();
    t_refill();
    t_indep();
    t_b2b();
    t_cfg_same();
    t_collide();
    idle(5);
    summary();
  end
endmodule